// File: doc/BRIEF.md
# Shared-Bus Register Transfer Datapath

This block is the register file and interconnect of a small accumulator machine. It has one 16-bit common bus. A 3-bit select code chooses which single source drives that bus. The sources are six working registers and a 4096-word by 16-bit memory. Every destination samples the bus on the clock edge at which its own load control is high. An external sequencer supplies all the controls: bus select, per-register load, increment and clear, memory read and write, and the character-register strobes. An external adder/logic unit returns its result through a dedicated accumulator input. The accumulator loads from that input, not from the bus.

Two registers hold addresses and are 12 bits wide: the address register and the program counter. The data, accumulator, instruction and temporary registers are 16 bits wide. When an address-width register drives the bus, the upper bits are filled with zeros. When it loads from the bus, it keeps only the low 12 bits. The memory is addressed by the address register. Its reads are combinational and its writes take effect at the clock edge. An 8-bit input character register captures an external character. An 8-bit output character register captures the low byte of the bus and drives only its own output pins.

Top module: `rtb_datapath`

## Requirements
- R1: The select code picks the bus source: 0 gives all zeros, 1 address register, 2 program counter, 3 data register, 4 accumulator, 5 instruction register, 6 temporary register, 7 memory word.
- R2: When select is 1 or 2, bus bits 15..12 are 0 and bits 11..0 equal the 12-bit register.
- R3: A 12-bit register loading from the bus captures bus bits 11..0 only.
- R4: The memory word appears on the bus only when select is 7 and read is high. Select 7 with read low gives zero. Read high with any other select has no effect on the bus.
- R5: With write high, the bus value is stored at the edge into the word addressed by the address register, and it can later be read back at that address.
- R6: A register whose load bit is high takes the bus value at the next edge (index order of the control vectors: 0 address, 1 program counter, 2 data, 3 accumulator, 4 instruction, 5 temporary). The accumulator instead takes the adder/logic input.
- R7: Increment adds one at the edge and wraps to zero: 0xFFF+1 gives 0 for 12-bit registers and 0xFFFF+1 gives 0 for 16-bit registers.
- R8: When several controls are high on one register, clear wins over load, and load wins over increment.
- R9: The instruction register has no increment or clear. Its bits at index 4 of the increment and clear vectors are ignored.
- R10: The output character register loads bus bits 7..0 when its strobe is high. The input character register loads the external character when its strobe is high.
- R11: A synchronous active-high reset sets every register, including both character registers, to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 3 | Bus source select code |
| ld_en | input | 6 | Per-register load controls |
| inc_en | input | 6 | Per-register increment controls |
| clr_en | input | 6 | Per-register synchronous clear controls |
| alu_result | input | 16 | Value loaded into the accumulator |
| ld_inchar | input | 1 | Input character strobe |
| in_char | input | 8 | External input character |
| ld_outchar | input | 1 | Output character strobe |
| mem_rd | input | 1 | Memory read enable onto the bus |
| mem_wr | input | 1 | Memory write enable from the bus |
| bus_out | output | 16 | Current bus value |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| dr_q | output | 16 | Data register |
| ac_q | output | 16 | Accumulator |
| ir_q | output | 16 | Instruction register |
| tr_q | output | 16 | Temporary register |
| inchar_q | output | 8 | Input character register |
| outchar_q | output | 8 | Output character register |

## Verification
Every register is visible at the ports. A wrong count, a wrong priority or a wrong load source therefore shows up one cycle after the edge that caused it. The bus is combinational, so a wrong select decode or a missing zero-extension is visible in the same cycle as the select code. A memory fault shows only when the word is read back through select 7. For that reason the stimulus stores words at known addresses, changes the address register, and then returns to those addresses to read them.

// File: rtl/rtb_pkg.sv
package rtb_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 12;
    localparam int CHAR_W = 8;
    localparam int SEL_W  = 3;
    localparam int NREG   = 6;

    localparam int REG_AR = 0;
    localparam int REG_PC = 1;
    localparam int REG_DR = 2;
    localparam int REG_AC = 3;
    localparam int REG_IR = 4;
    localparam int REG_TR = 5;

    typedef enum logic [SEL_W-1:0] {
        SRC_NONE  = 3'd0,
        SRC_ADDR  = 3'd1,
        SRC_PC    = 3'd2,
        SRC_DATA  = 3'd3,
        SRC_ACC   = 3'd4,
        SRC_INSTR = 3'd5,
        SRC_TEMP  = 3'd6,
        SRC_MEM   = 3'd7
    } bus_src_e;

    typedef struct packed {
        logic ld;
        logic inc;
        logic clr;
    } reg_ctl_t;

    function automatic int reg_width(input int idx);
        return (idx == REG_AR || idx == REG_PC) ? ADDR_W : WORD_W;
    endfunction

    function automatic bit reg_counts(input int idx);
        return idx != REG_IR;
    endfunction

endpackage

// File: rtl/rtb_count_reg.sv
module rtb_count_reg #(
    parameter int W         = 16,
    parameter bit HAS_COUNT = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic         inc,
    input  logic         clr,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    logic inc_ok;
    logic clr_ok;

    assign inc_ok = HAS_COUNT ? inc : 1'b0;
    assign clr_ok = HAS_COUNT ? clr : 1'b0;

    always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (clr_ok) q <= '0;
        else if (ld)     q <= din;
        else if (inc_ok) q <= q + W'(1);
    end

    a_r8_clear_first: assert property (@(posedge clk) disable iff (rst)
        clr_ok |=> (q == '0));
    a_r6_load_takes_din: assert property (@(posedge clk) disable iff (rst)
        (ld && !clr_ok) |=> (q == $past(din)));
    a_r7_inc_wraps: assert property (@(posedge clk) disable iff (rst)
        (inc_ok && !ld && !clr_ok) |=> (q == $past(q) + W'(1)));
    a_r11_reset_zero: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (q == '0));
    a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!ld && !inc_ok && !clr_ok) |=> $stable(q));

endmodule

// File: rtl/rtb_bus_mux.sv
module rtb_bus_mux
    import rtb_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int N = NREG
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [W-1:0]     src [N],
    input  logic             mem_rd,
    input  logic [W-1:0]     mem_q,
    output logic [W-1:0]     bus
);
    bus_src_e code;
    assign code = bus_src_e'(sel);

    always_comb begin
        case (code)
            SRC_ADDR:  bus = src[REG_AR];
            SRC_PC:    bus = src[REG_PC];
            SRC_DATA:  bus = src[REG_DR];
            SRC_ACC:   bus = src[REG_AC];
            SRC_INSTR: bus = src[REG_IR];
            SRC_TEMP:  bus = src[REG_TR];
            SRC_MEM:   bus = mem_rd ? mem_q : '0;
            default:   bus = '0;
        endcase
    end

endmodule

// File: rtl/rtb_word_mem.sv
module rtb_word_mem #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[addr] <= wdata;
    end

    assign rdata = store[addr];

    a_r5_write_lands: assert property (@(posedge clk)
        (we && $stable(addr)) |=> (rdata == $past(wdata)));

endmodule

// File: rtl/rtb_datapath.sv
module rtb_datapath
    import rtb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  bus_sel,
    input  logic [NREG-1:0]   ld_en,
    input  logic [NREG-1:0]   inc_en,
    input  logic [NREG-1:0]   clr_en,
    input  logic [WORD_W-1:0] alu_result,
    input  logic              ld_inchar,
    input  logic [CHAR_W-1:0] in_char,
    input  logic              ld_outchar,
    input  logic              mem_rd,
    input  logic              mem_wr,
    output logic [WORD_W-1:0] bus_out,
    output logic [ADDR_W-1:0] ar_q,
    output logic [ADDR_W-1:0] pc_q,
    output logic [WORD_W-1:0] dr_q,
    output logic [WORD_W-1:0] ac_q,
    output logic [WORD_W-1:0] ir_q,
    output logic [WORD_W-1:0] tr_q,
    output logic [CHAR_W-1:0] inchar_q,
    output logic [CHAR_W-1:0] outchar_q
);
    logic [WORD_W-1:0] bus;
    logic [WORD_W-1:0] reg_q [NREG];
    logic [WORD_W-1:0] mem_q;
    reg_ctl_t          ctl   [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam int RW = reg_width(i);
        logic [RW-1:0] din;
        logic [RW-1:0] qn;

        assign ctl[i] = '{ld: ld_en[i], inc: inc_en[i], clr: clr_en[i]};

        if (i == REG_AC) begin : g_alu_src
            assign din = alu_result[RW-1:0];
        end else begin : g_bus_src
            assign din = bus[RW-1:0];
        end

        rtb_count_reg #(.W(RW), .HAS_COUNT(reg_counts(i))) u_reg (
            .clk (clk),
            .rst (rst),
            .ld  (ctl[i].ld),
            .inc (ctl[i].inc),
            .clr (ctl[i].clr),
            .din (din),
            .q   (qn)
        );

        assign reg_q[i] = WORD_W'(qn);
    end

    rtb_word_mem #(.AW(ADDR_W), .DW(WORD_W)) u_mem (
        .clk   (clk),
        .we    (mem_wr),
        .addr  (ar_q),
        .wdata (bus),
        .rdata (mem_q)
    );

    rtb_bus_mux #(.W(WORD_W), .N(NREG)) u_mux (
        .sel    (bus_sel),
        .src    (reg_q),
        .mem_rd (mem_rd),
        .mem_q  (mem_q),
        .bus    (bus)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            inchar_q  <= '0;
            outchar_q <= '0;
        end else begin
            if (ld_inchar)  inchar_q  <= in_char;
            if (ld_outchar) outchar_q <= bus[CHAR_W-1:0];
        end
    end

    assign bus_out = bus;
    assign ar_q    = reg_q[REG_AR][ADDR_W-1:0];
    assign pc_q    = reg_q[REG_PC][ADDR_W-1:0];
    assign dr_q    = reg_q[REG_DR];
    assign ac_q    = reg_q[REG_AC];
    assign ir_q    = reg_q[REG_IR];
    assign tr_q    = reg_q[REG_TR];

    a_r2_addr_zext: assert property (@(posedge clk) disable iff (rst)
        (bus_sel == 3'd1) |-> (bus_out == {{(WORD_W-ADDR_W){1'b0}}, ar_q}));
    a_r1_pc_source: assert property (@(posedge clk) disable iff (rst)
        (bus_sel == 3'd2) |-> (bus_out == {{(WORD_W-ADDR_W){1'b0}}, pc_q}));
    a_r4_mem_gated: assert property (@(posedge clk) disable iff (rst)
        (bus_sel == 3'd7 && !mem_rd) |-> (bus_out == '0));
    a_r10_outchar_low_byte: assert property (@(posedge clk) disable iff (rst)
        ld_outchar |=> (outchar_q == $past(bus_out[CHAR_W-1:0])));
    a_r9_ir_holds: assert property (@(posedge clk) disable iff (rst)
        !ld_en[REG_IR] |=> (ir_q == $past(ir_q)));
    a_r3_addr_truncate: assert property (@(posedge clk) disable iff (rst)
        (ld_en[REG_AR] && !clr_en[REG_AR]) |=> (ar_q == $past(bus_out[ADDR_W-1:0])));

endmodule

// File: tb/rtb_datapath_tb_top.sv
module rtb_datapath_tb_top;
    localparam time TCK = 4ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_sel = '0;
    logic [5:0]  ld_en = '0, inc_en = '0, clr_en = '0;
    logic [15:0] alu_result = '0;
    logic        ld_inchar = 1'b0, ld_outchar = 1'b0, mem_rd = 1'b0, mem_wr = 1'b0;
    logic [7:0]  in_char = '0;
    logic [15:0] bus_out, dr_q, ac_q, ir_q, tr_q;
    logic [11:0] ar_q, pc_q;
    logic [7:0]  inchar_q, outchar_q;

    always #(TCK/2) clk = ~clk;

    rtb_datapath dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .ld_en(ld_en), .inc_en(inc_en),
        .clr_en(clr_en), .alu_result(alu_result), .ld_inchar(ld_inchar),
        .in_char(in_char), .ld_outchar(ld_outchar), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .bus_out(bus_out), .ar_q(ar_q), .pc_q(pc_q), .dr_q(dr_q), .ac_q(ac_q),
        .ir_q(ir_q), .tr_q(tr_q), .inchar_q(inchar_q), .outchar_q(outchar_q)
    );

    typedef struct {
        logic [15:0]  bus;
        logic [103:0] regs;
        string        tag;
    } exp_t;

    exp_t        sb_q[$];
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    // reference state, built from the requirements
    logic [11:0] m_ar = '0, m_pc = '0;
    logic [15:0] m_dr = '0, m_ac = '0, m_ir = '0, m_tr = '0;
    logic [7:0]  m_in = '0, m_out = '0;
    logic [15:0] m_mem [int];

    function automatic logic [103:0] pack_regs(logic [11:0] a, logic [11:0] p,
        logic [15:0] d, logic [15:0] c, logic [15:0] i, logic [15:0] t,
        logic [7:0] ci, logic [7:0] co);
        return {a, p, d, c, i, t, ci, co};
    endfunction

    function automatic logic [15:0] cnt16(logic [15:0] q, logic l, logic n, logic c, logic [15:0] d);
        if (c) return '0;
        if (l) return d;
        if (n) return q + 16'd1;
        return q;
    endfunction

    task automatic step(input logic [2:0] sel, input logic [5:0] ld, input logic [5:0] inc,
                        input logic [5:0] clr, input logic [15:0] alu, input logic rd,
                        input logic wr, input logic lin, input logic [7:0] ch,
                        input logic lout, input string tag);
        exp_t e;
        logic [15:0] b;
        logic [15:0] memw;
        @(negedge clk);
        bus_sel = sel; ld_en = ld; inc_en = inc; clr_en = clr; alu_result = alu;
        mem_rd = rd; mem_wr = wr; ld_inchar = lin; in_char = ch; ld_outchar = lout;
        memw = m_mem.exists(int'(m_ar)) ? m_mem[int'(m_ar)] : 16'h0000;
        case (sel)
            3'd1: b = {4'h0, m_ar};
            3'd2: b = {4'h0, m_pc};
            3'd3: b = m_dr;
            3'd4: b = m_ac;
            3'd5: b = m_ir;
            3'd6: b = m_tr;
            3'd7: b = rd ? memw : 16'h0000;
            default: b = 16'h0000;
        endcase
        if (wr) m_mem[int'(m_ar)] = b;
        m_ar = cnt16({4'h0, m_ar}, ld[0], inc[0], clr[0], b)  [11:0];
        m_pc = cnt16({4'h0, m_pc}, ld[1], inc[1], clr[1], b)  [11:0];
        m_dr = cnt16(m_dr, ld[2], inc[2], clr[2], b);
        m_ac = cnt16(m_ac, ld[3], inc[3], clr[3], alu);
        m_ir = ld[4] ? b : m_ir;
        m_tr = cnt16(m_tr, ld[5], inc[5], clr[5], b);
        if (lin)  m_in  = ch;
        if (lout) m_out = b[7:0];
        e.bus  = b;
        e.regs = pack_regs(m_ar, m_pc, m_dr, m_ac, m_ir, m_tr, m_in, m_out);
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    // monitor: bus before the edge, registers after it
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                logic [103:0] got;
                e = sb_q.pop_front();
                checks++;
                if (bus_out !== e.bus) begin
                    failures++;
                    $display("FAIL %s bus: actual=%h expected=%h", e.tag, bus_out, e.bus);
                end
                @(posedge clk);
                #1;
                got = pack_regs(ar_q, pc_q, dr_q, ac_q, ir_q, tr_q, inchar_q, outchar_q);
                checks++;
                if (got !== e.regs) begin
                    failures++;
                    $display("FAIL %s regs: actual=%h expected=%h", e.tag, got, e.regs);
                end
            end
        end
    end

    initial begin
        #(TCK * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    localparam logic [5:0] NO = 6'b000000;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11: everything zero after reset
        step(3'd1, NO, NO, NO, 16'h0, 0, 0, 0, 8'h00, 0, "R11");
        step(3'd6, NO, NO, NO, 16'h0, 0, 0, 0, 8'h00, 0, "R11");
        // R6: accumulator loads from the adder/logic input
        step(3'd0, 6'b001000, NO, NO, 16'hA5C3, 0, 0, 0, 8'h00, 0, "R6");
        // R1/R6: accumulator onto bus into data register
        step(3'd4, 6'b000100, NO, NO, 16'h0000, 0, 0, 0, 8'h00, 0, "R1");
        step(3'd3, 6'b110000, NO, NO, 16'h0000, 0, 0, 0, 8'h00, 0, "R6");
        step(3'd6, NO, NO, NO, 16'h0, 0, 0, 0, 8'h00, 0, "R1");
        step(3'd5, NO, NO, NO, 16'h0, 0, 0, 0, 8'h00, 0, "R1");
        step(3'd0, NO, NO, NO, 16'h0, 0, 0, 0, 8'h00, 0, "R1");
        // R3: 12-bit registers keep the low bits of the bus
        step(3'd4, 6'b000011, NO, NO, 16'h0, 0, 0, 0, 8'h00, 0, "R3");
        // R2: zero-extension on the bus
        step(3'd1, NO, NO, NO, 16'h0, 0, 0, 0, 8'h00, 0, "R2");
        step(3'd2, NO, NO, NO, 16'h0, 0, 0, 0, 8'h00, 0, "R2");
        // R5: write data register at 0x5C3, then read back
        step(3'd3, NO, NO, NO, 16'h0, 0, 1, 0, 8'h00, 0, "R5");
        step(3'd7, NO, NO, NO, 16'h0, 1, 0, 0, 8'h00, 0, "R5");
        // R4: read gating
        step(3'd7, NO, NO, NO, 16'h0, 0, 0, 0, 8'h00, 0, "R4");
        step(3'd4, NO, NO, NO, 16'h0, 1, 0, 0, 8'h00, 0, "R4");
        // R5: second word at 0x5C4 via pc source, then back to the first
        step(3'd0, NO, 6'b000001, NO, 16'h0, 0, 0, 0, 8'h00, 0, "R7");
        step(3'd2, NO, NO, NO, 16'h0, 0, 1, 0, 8'h00, 0, "R5");
        step(3'd7, NO, NO, NO, 16'h0, 1, 0, 0, 8'h00, 0, "R5");
        step(3'd4, 6'b000001, NO, NO, 16'h0, 0, 0, 0, 8'h00, 0, "R3");
        step(3'd7, NO, NO, NO, 16'h0, 1, 0, 0, 8'h00, 0, "R5");
        // R7: wrap of both widths
        step(3'd0, 6'b001000, NO, NO, 16'hFFFF, 0, 0, 0, 8'h00, 0, "R7");
        step(3'd4, 6'b100101, NO, NO, 16'h0, 0, 0, 0, 8'h00, 0, "R7");
        step(3'd0, NO, 6'b101111, NO, 16'h0, 0, 0, 0, 8'h00, 0, "R7");
        step(3'd1, NO, NO, NO, 16'h0, 0, 0, 0, 8'h00, 0, "R7");
        // R8: priority on temp (clr+ld+inc) and pc (ld+inc)
        step(3'd4, 6'b101110, 6'b100010, 6'b100000, 16'h1234, 0, 0, 0, 8'h00, 0, "R8");
        step(3'd3, 6'b000010, 6'b000110, 6'b000100, 16'h0, 0, 0, 0, 8'h00, 0, "R8");
        // R9: instruction register ignores increment and clear
        step(3'd4, 6'b010000, NO, NO, 16'h0, 0, 0, 0, 8'h00, 0, "R6");
        step(3'd0, NO, 6'b010000, NO, 16'h0, 0, 0, 0, 8'h00, 0, "R9");
        step(3'd0, NO, NO, 6'b010000, 16'h0, 0, 0, 0, 8'h00, 0, "R9");
        step(3'd5, NO, NO, NO, 16'h0, 0, 0, 0, 8'h00, 0, "R9");
        // R10: character registers
        step(3'd4, NO, NO, NO, 16'h0, 0, 0, 1, 8'h3C, 1, "R10");
        step(3'd0, NO, NO, NO, 16'h0, 0, 0, 0, 8'hE7, 0, "R10");
        step(3'd6, NO, NO, NO, 16'h0, 0, 0, 1, 8'h81, 1, "R10");
        step(3'd0, NO, NO, NO, 16'h0, 0, 0, 0, 8'h00, 0, "R1");
        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule